// File: doc/BRIEF.md
# Keypad Interrupt Condition Unit

This block watches ten push buttons and raises an interrupt when a programmable set of them is pressed. A synchronized, active-low key vector is registered every clock into a status value that software can read, where a 0 bit marks a pressed key and a 1 bit marks a released one. A control register holds a per-key select mask, an enable flag and a mode flag. The mode flag picks between two tests. The first asks that every selected key be held down together. The second asks that at least one selected key be held down.

The condition is evaluated only on a clock edge where the incoming key vector differs from the one already held. A steady key state never re-triggers, even if it satisfies the condition. A hit produces a one-cycle interrupt pulse for an interrupt controller outside this block. Debouncing and matrix scanning are also done outside this block, before the key vector reaches it.

Top module: `keypad_irq_unit`

## Requirements
- R1: After reset, status_o is all ones (all keys released), ctrl_o is zero and irq_o is low.
- R2: On every clock edge, status_o takes the value of keys_i, so it is visible one cycle after the key vector is driven. A 0 bit means pressed.
- R3: A clock edge with wr_en_i high loads the control register, and ctrl_o shows it from the next cycle. Bits 9:0 are the key select mask (bit n selects key n), bit 14 is the enable and bit 15 is the mode (1 = all-selected, 0 = any-selected). Bits 13:10 always read as zero.
- R4: In all-selected mode, an evaluation hits when every key whose mask bit is set is pressed in the new key vector. With an empty mask, every evaluation hits.
- R5: In any-selected mode, an evaluation hits when at least one key whose mask bit is set is pressed in the new key vector. With an empty mask, no evaluation hits.
- R6: The condition is evaluated only on an edge where keys_i differs from status_o. A key vector that stays the same produces no interrupt.
- R7: While control bit 14 is clear, irq_o stays low for any key activity.
- R8: irq_o is registered on the same edge that captures the new key vector. It is high for exactly one cycle unless the next edge is itself a hitting change. Evaluation uses the control value held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keys_i | input | 10 | Synchronized key vector, 0 = pressed |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 16 | Control register write data |
| status_o | output | 10 | Registered key status |
| ctrl_o | output | 16 | Control register readback |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
There are three kinds of internal fault. A stale previous-key register shows up as a pulse on a vector that did not change, or as a missing pulse on one that did. A wrong mask or mode bit shows up as a wrong pulse decision on the first key change after the write. Because every key change is evaluated, both kinds of fault reach irq_o one cycle after the offending vector is driven. A stuck status bit appears on status_o in that same cycle. The sweeps drive all 1024 key vectors under several masks in both modes, so every such fault gets a change edge on which to show.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int KPD_KEYS    = 10;
  localparam int KPD_CTRL_W  = 16;
  localparam int KPD_EN_POS  = 14;
  localparam int KPD_AND_POS = 15;

  typedef enum logic {
    MODE_ANY = 1'b0,
    MODE_ALL = 1'b1
  } kpd_mode_e;
endpackage

// File: rtl/kpd_sampler.sv
module kpd_sampler #(
  parameter int NUM_KEYS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] keys_i,
  output logic [NUM_KEYS-1:0] held_o,
  output logic                change_o
);
  // Released state (all ones) is the reset value of the held vector.
  always_ff @(posedge clk) begin
    if (!rst_n) held_o <= '1;
    else        held_o <= keys_i;
  end

  assign change_o = (keys_i != held_o);
endmodule

// File: rtl/kpd_ctrl_reg.sv
module kpd_ctrl_reg #(
  parameter int NUM_KEYS = 10,
  parameter int CTRL_W   = 16,
  parameter int EN_POS   = 14,
  parameter int AND_POS  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  // Only the mask, enable and mode positions get storage; all other bits are tied to zero.
  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    if (b < NUM_KEYS || b == EN_POS || b == AND_POS) begin : g_store
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (wr_en_i) q <= wr_data_i[b];
      end
      assign ctrl_o[b] = q;
    end else begin : g_zero
      assign ctrl_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/kpd_cond_eval.sv
module kpd_cond_eval
  import kpd_pkg::*;
#(
  parameter int NUM_KEYS = 10
) (
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic [NUM_KEYS-1:0] mask_i,
  input  kpd_mode_e           mode_i,
  output logic                hit_o
);
  function automatic logic all_selected(input logic [NUM_KEYS-1:0] pressed,
                                        input logic [NUM_KEYS-1:0] mask);
    return (pressed & mask) == mask;
  endfunction

  function automatic logic any_selected(input logic [NUM_KEYS-1:0] pressed,
                                        input logic [NUM_KEYS-1:0] mask);
    return |(pressed & mask);
  endfunction

  logic [NUM_KEYS-1:0] pressed;
  assign pressed = ~keys_i;

  always_comb begin
    if (mode_i == MODE_ALL) hit_o = all_selected(pressed, mask_i);
    else                    hit_o = any_selected(pressed, mask_i);
  end
endmodule

// File: rtl/keypad_irq_unit.sv
module keypad_irq_unit
  import kpd_pkg::*;
#(
  parameter int NUM_KEYS = KPD_KEYS,
  parameter int CTRL_W   = KPD_CTRL_W,
  parameter int EN_POS   = KPD_EN_POS,
  parameter int AND_POS  = KPD_AND_POS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic                wr_en_i,
  input  logic [CTRL_W-1:0]   wr_data_i,
  output logic [NUM_KEYS-1:0] status_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                irq_o
);
  logic                key_change;
  logic                cond_hit;
  logic                irq_en;
  kpd_mode_e           mode;
  logic [NUM_KEYS-1:0] key_mask;
  logic                fire;

  kpd_sampler #(.NUM_KEYS(NUM_KEYS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .keys_i(keys_i),
    .held_o(status_o), .change_o(key_change)
  );

  kpd_ctrl_reg #(.NUM_KEYS(NUM_KEYS), .CTRL_W(CTRL_W), .EN_POS(EN_POS), .AND_POS(AND_POS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .ctrl_o(ctrl_o)
  );

  assign key_mask = ctrl_o[NUM_KEYS-1:0];
  assign irq_en   = ctrl_o[EN_POS];
  assign mode     = kpd_mode_e'(ctrl_o[AND_POS]);

  kpd_cond_eval #(.NUM_KEYS(NUM_KEYS)) u_eval (
    .keys_i(keys_i), .mask_i(key_mask), .mode_i(mode), .hit_o(cond_hit)
  );

  assign fire = key_change & irq_en & cond_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= fire;
  end

  // R6
  irq_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(key_change));

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(irq_en));

  // R3
  ctrl_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ctrl_o[NUM_KEYS-1:0] == $past(wr_data_i[NUM_KEYS-1:0]));

  // R5
  any_mode_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !$past(ctrl_o[AND_POS])) |-> ($past(~keys_i & key_mask) != '0));

  // R4
  all_mode_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(ctrl_o[AND_POS])) |-> (($past(~keys_i & key_mask)) == $past(key_mask)));

  // R8
  pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !key_change) |=> !irq_o);
endmodule

// File: tb/sim_keypad_irq_unit.sv
module sim_keypad_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] keys = '1;
  logic       wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [9:0] status;
  logic [15:0] ctrl;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keypad_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .keys_i(keys), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .status_o(status), .ctrl_o(ctrl), .irq_o(irq)
  );

  function automatic logic expect_irq(input logic [9:0] prev, input logic [9:0] cur,
                                      input logic [15:0] c);
    int sel = 0;
    int hit = 0;
    if (prev == cur || !c[14]) return 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (c[i]) begin
        sel++;
        if (!cur[i]) hit++;
      end
    end
    if (c[15]) return hit == sel;
    return hit > 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Entered at a negedge; drives keys and returns at the next negedge.
  task automatic drive(input logic [9:0] k);
    keys = k;
    @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [15:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sweep(input logic [15:0] c, input string req);
    logic [9:0] prev;
    write_ctrl(c);
    check("R3", ctrl, c & 16'hC3FF);
    prev = status;
    for (int p = 0; p < 1024; p++) begin
      logic [9:0] k = 10'(p ^ (p >> 1));
      drive(k);
      check("R2", status, k);
      check(req, irq, expect_irq(prev, k, c));
      prev = k;
    end
  endtask

  task automatic finish_up;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    keys = 10'h155;
    repeat (3) @(negedge clk);
    // R1
    check("R1", status, 10'h3FF);
    check("R1", ctrl, 16'h0000);
    check("R1", irq, 1'b0);
    rst_n = 1'b1;
    keys = '1;
    @(negedge clk);

    // R3: reserved bits read zero
    write_ctrl(16'hFFFF);
    check("R3", ctrl, 16'hC3FF);

    // R6: steady pressed keys under a satisfied condition give no pulse
    write_ctrl(16'h4003);
    drive(10'h3FE);
    check("R8", irq, 1'b1);
    drive(10'h3FE);
    check("R6", irq, 1'b0);
    drive(10'h3FE);
    check("R6", irq, 1'b0);

    // R8: control written on the change edge does not affect that evaluation
    keys = 10'h3FD;
    wr_en = 1'b1;
    wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8", irq, 1'b1);
    drive(10'h3FC);
    check("R7", irq, 1'b0);

    // R7: disabled, all modes
    sweep(16'h03FF, "R7");
    sweep(16'h83FF, "R7");
    // R5: any-selected mode
    sweep(16'h4001, "R5");
    sweep(16'h4210, "R5");
    sweep(16'h4000, "R5");
    // R4: all-selected mode
    sweep(16'hC003, "R4");
    sweep(16'hC2A0, "R4");
    sweep(16'hC3FF, "R4");
    sweep(16'hC000, "R4");

    done = 1;
    finish_up();
  end
endmodule